// File: doc/BRIEF.md
# Table-Based Multi-Waveform Sample Generator

This block feeds an external 8-bit DAC with a stream of unsigned amplitude codes. The codes trace one of four periodic shapes: sine, square, triangle or ramp. Each shape is held as a 256-entry, one-period table. The tables are computed by combinational logic, not stored. A table index walks through the entries. An update strobe marks every clock in which a fresh code appears.

Two controls set the output rate together. The first is the dwell, which is the number of clocks between successive sample updates. The second is the stride, which is the number of table entries skipped per update, always a power of two. A coarse level (0 to 7) selects a base dwell and the stride, and a fine-tune input is added to that base dwell. The coarse level is moved by a step press, and a second press input rotates through the shapes. The pending shape, level and fine value reach the output only when the index wraps to zero, so every period is played out completely with a single setting. The state machine has two states. ST_PRIME emits the index-0 sample once after reset, then takes the transition "prime done" to ST_DWELL. ST_DWELL counts the dwell. On each count-out it takes either "advance", which moves the index by the stride, or "period boundary", which is an advance that wraps the index and also commits the pending settings.

Top module: `wavetable_synth`

## Requirements
- R1: While `rst` is high at a rising edge, `sample_code` becomes 128 and `sample_strobe` becomes 0. The shape becomes sine, the coarse level 0, the dwell 47 clocks (32 + 15) and the index 0. At the first rising edge where `rst` is sampled low, the strobe is raised with code 128. The next strobe follows 47 clocks later.
- R2: Sine code for index p: h = p mod 128, a = floor(h·(128−h)·127 / 4096), code = 128 + a when p < 128 and 128 − a otherwise.
- R3: Square code is 255 for p < 128 and 0 otherwise. Triangle code is 2p for p < 128 and 255 − 2(p−128) otherwise. Ramp code is p.
- R4: `sample_strobe` is high for one clock per new code. `sample_code` does not change in a clock without a strobe.
- R5: Strobes are spaced by the active dwell D = max(1, B + fine). B is 32 >> (2·L) for levels L = 0..3 and 0 for L ≥ 4.
- R6: Each strobe advances the index by the stride, modulo 256. The stride is 1 for L ≤ 3 and 2^(L−3) for L ≥ 4.
- R7: A shape press moves the pending shape through the order sine(0) → square(1) → triangle(2) → ramp(3) → sine. The new shape first appears on the sample at index 0 of the next period.
- R8: A step press with `step_up`=1 raises the level and with `step_up`=0 lowers it. The level saturates at 0 and at a limit, which is 7 for square (stride up to 16) and 5 for the other shapes (stride up to 4). A shape press clamps the level to the limit of the new shape.
- R9: The fine value and level are taken only at the period boundary. A change of `fine_tune` during a period leaves that period's strobe spacing unchanged.
- R10: Each press is counted on its rising edge only. An input held high for many clocks counts as one press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fine_tune | input | FINE_W (4) | Fine dwell value, added to the base dwell |
| wave_next | input | 1 | Debounced shape-select press |
| step_press | input | 1 | Debounced coarse-step press |
| step_up | input | 1 | Step direction for a step press: 1 raises, 0 lowers |
| sample_code | output | 8 | Current amplitude code |
| sample_strobe | output | 1 | One-clock marker of a new code |

## Verification
A press is registered at the first rising edge where the input is high. It has no visible effect until the strobe at the next wrap, which can be up to a full period later. The first strobe comes one edge after reset is released, and each later strobe follows exactly D clocks after the one before. The bench drives inputs one nanosecond after a rising edge and samples outputs on the falling edge. Its model applies a strobe's wrap before it folds in the presses seen at that same edge, so each expected code and spacing is due in the same clock as the design's register update.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE     = 2'd0,
        WAVE_SQUARE   = 2'd1,
        WAVE_TRIANGLE = 2'd2,
        WAVE_RAMP     = 2'd3
    } wave_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_DWELL = 1'b1
    } seq_state_e;

    typedef struct packed {
        wave_e      wave;
        logic [2:0] stride_log;
    } shape_cfg_t;

    function automatic wave_e wave_after(input wave_e w);
        wave_e r;
        unique case (w)
            WAVE_SINE:     r = WAVE_SQUARE;
            WAVE_SQUARE:   r = WAVE_TRIANGLE;
            WAVE_TRIANGLE: r = WAVE_RAMP;
            WAVE_RAMP:     r = WAVE_SINE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wsg_pulse_edge.sv
module wsg_pulse_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[g];
        end

        assign rise[g] = lvl[g] & ~prev_q;

        // R10
        single_rise_chk: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end

endmodule

// File: rtl/wsg_rate_ctrl.sv
module wsg_rate_ctrl
    import wsg_pkg::*;
#(
    parameter int FINE_W            = 4,
    parameter int BASE_DELAY        = 32,
    parameter int SLOW_LEVELS       = 4,
    parameter int SLOW_SHIFT        = 2,
    parameter int STRIDE_LOG_MAX    = 2,
    parameter int STRIDE_LOG_MAX_SQ = 4,
    parameter int DLY_W             = 6,
    parameter int LVL_W             = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wave_rise,
    input  logic              step_rise,
    input  logic              step_up,
    input  logic [FINE_W-1:0] fine,
    output shape_cfg_t        pend_cfg,
    output logic [DLY_W-1:0]  pend_delay
);

    localparam int LVL_MAX    = SLOW_LEVELS - 1 + STRIDE_LOG_MAX;
    localparam int LVL_MAX_SQ = SLOW_LEVELS - 1 + STRIDE_LOG_MAX_SQ;

    wave_e            wave_q, wave_d;
    logic [LVL_W-1:0] level_q, level_d, stepped, lim_next, lim_now;
    logic [DLY_W-1:0] base_dly, dly_sum;
    int               lvl_i;

    // next pending shape and level
    always_comb begin
        wave_d   = wave_rise ? wave_after(wave_q) : wave_q;
        lim_next = (wave_d == WAVE_SQUARE) ? LVL_W'(LVL_MAX_SQ) : LVL_W'(LVL_MAX);
        lim_now  = (wave_q == WAVE_SQUARE) ? LVL_W'(LVL_MAX_SQ) : LVL_W'(LVL_MAX);
        stepped  = level_q;
        if (step_rise) begin
            if (step_up)              stepped = level_q + LVL_W'(1);
            else if (level_q != '0)   stepped = level_q - LVL_W'(1);
        end
        level_d = (stepped > lim_next) ? lim_next : stepped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q  <= WAVE_SINE;
            level_q <= '0;
        end else begin
            wave_q  <= wave_d;
            level_q <= level_d;
        end
    end

    // level -> stride and dwell
    always_comb begin
        lvl_i = int'(level_q);
        if (lvl_i < SLOW_LEVELS) begin
            base_dly            = DLY_W'(BASE_DELAY >> (SLOW_SHIFT * lvl_i));
            pend_cfg.stride_log = 3'd0;
        end else begin
            base_dly            = '0;
            pend_cfg.stride_log = 3'(lvl_i - (SLOW_LEVELS - 1));
        end
        pend_cfg.wave = wave_q;
        dly_sum       = base_dly + DLY_W'(fine);
        pend_delay    = (dly_sum == '0) ? DLY_W'(1) : dly_sum;
    end

    // R8
    level_limit_chk: assert property (@(posedge clk) disable iff (rst)
        level_q <= lim_now);

    // R7
    wave_order_chk: assert property (@(posedge clk) disable iff (rst)
        (wave_q != $past(wave_q)) |-> (wave_q == wave_after($past(wave_q))));

endmodule

// File: rtl/wsg_shape_rom.sv
module wsg_shape_rom
    import wsg_pkg::*;
(
    input  wave_e      wave,
    input  logic [7:0] phase,
    output logic [7:0] code
);

    logic [6:0]  half_pos;
    logic [7:0]  half_rem;
    logic [14:0] bump;
    logic [18:0] scaled;
    logic [7:0]  amp;
    logic [7:0]  sine_code;
    logic [7:0]  tri_rise;

    // parabolic half-wave lobes around mid-scale
    always_comb begin
        half_pos  = phase[6:0];
        half_rem  = 8'd128 - {1'b0, half_pos};
        bump      = 15'(half_pos) * 15'(half_rem);
        scaled    = 19'(bump) * 19'd127;
        amp       = 8'(scaled >> 12);
        sine_code = phase[7] ? (8'd128 - amp) : (8'd128 + amp);
        tri_rise  = {phase[6:0], 1'b0};
    end

    always_comb begin
        unique case (wave)
            WAVE_SINE:     code = sine_code;
            WAVE_SQUARE:   code = phase[7] ? 8'd0 : 8'd255;
            WAVE_TRIANGLE: code = phase[7] ? ~tri_rise : tri_rise;
            WAVE_RAMP:     code = phase;
        endcase
    end

endmodule

// File: rtl/wsg_sequencer.sv
module wsg_sequencer
    import wsg_pkg::*;
#(
    parameter int DLY_W     = 6,
    parameter int MAX_DELAY = 47
) (
    input  logic             clk,
    input  logic             rst,
    input  shape_cfg_t       pend_cfg,
    input  logic [DLY_W-1:0] pend_delay,
    input  logic [7:0]       lut_code,
    output wave_e            lut_wave,
    output logic [7:0]       lut_phase,
    output logic [7:0]       sample_code,
    output logic             sample_strobe
);

    localparam logic [7:0] MID_CODE = 8'd128;

    seq_state_e       state_q, state_d;
    shape_cfg_t       act_cfg;
    logic [DLY_W-1:0] act_delay, cnt_q;
    logic [7:0]       idx_q, stride, next_idx;
    logic             wraps, tick;
    logic [7:0]       code_q;
    logic             strobe_q;

    always_comb begin
        stride   = 8'(8'd1 << act_cfg.stride_log);
        next_idx = idx_q + stride;
        wraps    = (next_idx == 8'd0);
        tick     = (cnt_q == act_delay - DLY_W'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PRIME;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_PRIME: state_d = ST_DWELL;
            ST_DWELL: state_d = ST_DWELL;
        endcase
    end

    // table lookup request
    always_comb begin
        unique case (state_q)
            ST_PRIME: begin
                lut_wave  = act_cfg.wave;
                lut_phase = 8'd0;
            end
            ST_DWELL: begin
                lut_wave  = wraps ? pend_cfg.wave : act_cfg.wave;
                lut_phase = next_idx;
            end
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= 8'd0;
            cnt_q     <= '0;
            act_cfg   <= '{wave: WAVE_SINE, stride_log: 3'd0};
            act_delay <= DLY_W'(MAX_DELAY);
            code_q    <= MID_CODE;
            strobe_q  <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            unique case (state_q)
                ST_PRIME: begin
                    idx_q    <= 8'd0;
                    cnt_q    <= '0;
                    code_q   <= lut_code;
                    strobe_q <= 1'b1;
                end
                ST_DWELL: begin
                    if (tick) begin
                        cnt_q    <= '0;
                        idx_q    <= next_idx;
                        code_q   <= lut_code;
                        strobe_q <= 1'b1;
                        if (wraps) begin
                            act_cfg   <= pend_cfg;
                            act_delay <= pend_delay;
                        end
                    end else begin
                        cnt_q <= cnt_q + DLY_W'(1);
                    end
                end
            endcase
        end
    end

    assign sample_code   = code_q;
    assign sample_strobe = strobe_q;

    // R5
    dwell_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < act_delay);

    // R6
    stride_align_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_q & (stride - 8'd1)) == 8'd0);

    // R9
    commit_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ((act_delay != $past(act_delay)) || (act_cfg != $past(act_cfg))) |-> (idx_q == 8'd0));

    // R4
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_q |-> $stable(code_q));

endmodule

// File: rtl/wavetable_synth.sv
module wavetable_synth
    import wsg_pkg::*;
#(
    parameter int FINE_W            = 4,
    parameter int BASE_DELAY        = 32,
    parameter int SLOW_LEVELS       = 4,
    parameter int SLOW_SHIFT        = 2,
    parameter int STRIDE_LOG_MAX    = 2,
    parameter int STRIDE_LOG_MAX_SQ = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FINE_W-1:0] fine_tune,
    input  logic              wave_next,
    input  logic              step_press,
    input  logic              step_up,
    output logic [7:0]        sample_code,
    output logic              sample_strobe
);

    localparam int MAX_DELAY = BASE_DELAY + (1 << FINE_W) - 1;
    localparam int DLY_W     = $clog2(MAX_DELAY + 1);
    localparam int LVL_W     = $clog2(SLOW_LEVELS + STRIDE_LOG_MAX_SQ + 1);

    logic [1:0]       rises;
    shape_cfg_t       pend_cfg;
    logic [DLY_W-1:0] pend_delay;
    wave_e            lut_wave;
    logic [7:0]       lut_phase, lut_code;

    wsg_pulse_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({step_press, wave_next}),
        .rise (rises)
    );

    wsg_rate_ctrl #(
        .FINE_W            (FINE_W),
        .BASE_DELAY        (BASE_DELAY),
        .SLOW_LEVELS       (SLOW_LEVELS),
        .SLOW_SHIFT        (SLOW_SHIFT),
        .STRIDE_LOG_MAX    (STRIDE_LOG_MAX),
        .STRIDE_LOG_MAX_SQ (STRIDE_LOG_MAX_SQ),
        .DLY_W             (DLY_W),
        .LVL_W             (LVL_W)
    ) u_rate (
        .clk        (clk),
        .rst        (rst),
        .wave_rise  (rises[0]),
        .step_rise  (rises[1]),
        .step_up    (step_up),
        .fine       (fine_tune),
        .pend_cfg   (pend_cfg),
        .pend_delay (pend_delay)
    );

    wsg_sequencer #(
        .DLY_W     (DLY_W),
        .MAX_DELAY (MAX_DELAY)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .pend_cfg      (pend_cfg),
        .pend_delay    (pend_delay),
        .lut_code      (lut_code),
        .lut_wave      (lut_wave),
        .lut_phase     (lut_phase),
        .sample_code   (sample_code),
        .sample_strobe (sample_strobe)
    );

    wsg_shape_rom u_rom (
        .wave  (lut_wave),
        .phase (lut_phase),
        .code  (lut_code)
    );

endmodule

// File: tb/wavetable_synth_test.sv
module wavetable_synth_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] fine_tune = 4'd0;
    logic       wave_next = 1'b0;
    logic       step_press = 1'b0;
    logic       step_up = 1'b0;
    logic [7:0] sample_code;
    logic       sample_strobe;

    wavetable_synth uut (
        .clk           (clk),
        .rst           (rst),
        .fine_tune     (fine_tune),
        .wave_next     (wave_next),
        .step_press    (step_press),
        .step_up       (step_up),
        .sample_code   (sample_code),
        .sample_strobe (sample_strobe)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference model state
    int m_idx, m_wave, m_stride, m_delay;
    int p_wave, p_level;
    int last_cyc, last_code, wrap_cnt;
    bit first, prev_w, prev_s;

    // {shape presses, ups, downs, fine, exp shape, exp stride, exp dwell}
    localparam int NV = 8;
    localparam int VEC [NV][7] = '{
        '{0, 0, 0, 0, 0,  1, 32},
        '{1, 1, 0, 3, 1,  1, 11},
        '{1, 2, 0, 5, 2,  1,  5},
        '{0, 3, 0, 0, 2,  4,  1},
        '{1, 2, 0, 2, 3,  4,  2},
        '{2, 3, 0, 0, 1, 16,  1},
        '{1, 0, 1, 7, 2,  2,  7},
        '{1, 0, 5, 1, 3,  1, 33}
    };

    function automatic int shape(int w, int p);
        int h, a;
        case (w)
            0: begin
                h = p % 128;
                a = (h * (128 - h) * 127) >> 12;
                return (p < 128) ? 128 + a : 128 - a;
            end
            1: return (p < 128) ? 255 : 0;
            2: return (p < 128) ? 2 * p : 255 - 2 * (p - 128);
            default: return p;
        endcase
    endfunction

    function automatic int lvl_limit(int w);
        return (w == 1) ? 7 : 5;
    endfunction

    function automatic int stride_of(int l);
        return (l < 4) ? 1 : (1 << (l - 3));
    endfunction

    function automatic int dwell_of(int l, int f);
        int d;
        d = ((l < 4) ? (32 >> (2 * l)) : 0) + f;
        return (d < 1) ? 1 : d;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: samples on the falling edge
    always @(negedge clk) begin
        int nidx, exp;
        cyc++;
        if (cyc >= 190000) begin
            n_bad++;
            $display("FAIL R4 watchdog expired actual=%0d expected<%0d", cyc, 190000);
            finish_run();
        end
        if (rst) begin
            m_idx = 0; m_wave = 0; m_stride = 1; m_delay = 47;
            p_wave = 0; p_level = 0;
            first = 1'b1; prev_w = 1'b0; prev_s = 1'b0;
            last_cyc = cyc; last_code = 128;
        end else begin
            if (sample_strobe) begin
                if (first) begin
                    check(cyc - last_cyc == 2, "R1 first strobe delay", cyc - last_cyc, 2);
                    check(sample_code == 128, "R1 first code", sample_code, 128);
                    first = 1'b0;
                end else begin
                    check(cyc - last_cyc == m_delay, "R5/R9 strobe spacing",
                          cyc - last_cyc, m_delay);
                    nidx = (m_idx + m_stride) % 256;
                    if (nidx == 0) begin
                        m_wave   = p_wave;
                        m_stride = stride_of(p_level);
                        m_delay  = dwell_of(p_level, int'(fine_tune));
                        wrap_cnt++;
                    end
                    exp = shape(m_wave, nidx);
                    check(sample_code == exp, (m_wave == 0) ? "R2/R6/R7 sine code" :
                          "R3/R6/R7 shape code", sample_code, exp);
                    m_idx = nidx;
                end
                last_cyc  = cyc;
                last_code = sample_code;
            end else if (!first) begin
                check(sample_code == last_code, "R4 hold between strobes", sample_code, last_code);
            end
            // R10: only rising edges of the press inputs count
            if (wave_next && !prev_w) begin
                p_wave  = (p_wave + 1) % 4;
                if (p_level > lvl_limit(p_wave)) p_level = lvl_limit(p_wave);
            end
            if (step_press && !prev_s) begin
                if (step_up) begin
                    if (p_level < lvl_limit(p_wave)) p_level++;
                end else if (p_level > 0) begin
                    p_level--;
                end
            end
            prev_w = wave_next;
            prev_s = step_press;
        end
    end

    task automatic press_wave();
        wave_next = 1'b1;
        @(posedge clk); #1;
        wave_next = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic press_step(bit up);
        step_up    = up;
        step_press = 1'b1;
        @(posedge clk); #1;
        step_press = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic wait_wrap();
        int w;
        w = wrap_cnt;
        while (wrap_cnt == w) @(posedge clk);
        #1;
    endtask

    initial begin
        wrap_cnt = 0;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sample_code == 128, "R1 reset code", sample_code, 128);
        check(sample_strobe == 1'b0, "R1 reset strobe", sample_strobe, 0);
        @(posedge clk); #1;
        rst = 1'b0;

        wait_wrap();   // end of the reset-time period (dwell 47)

        // vector walk: R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            repeat (VEC[i][0]) press_wave();
            repeat (VEC[i][1]) press_step(1'b1);
            repeat (VEC[i][2]) press_step(1'b0);
            fine_tune = 4'(VEC[i][3]);
            wait_wrap();
            check(m_wave == VEC[i][4], "R7 shape after boundary", m_wave, VEC[i][4]);
            check(m_stride == VEC[i][5], "R6/R8 stride after boundary", m_stride, VEC[i][5]);
            check(m_delay == VEC[i][6], "R5/R8 dwell after boundary", m_delay, VEC[i][6]);
        end

        // R10: held press counts once (ramp -> sine, not further)
        wave_next = 1'b1;
        repeat (10) @(posedge clk);
        #1 wave_next = 1'b0;
        wait_wrap();
        check(last_code == 128, "R10 held press code at index 0", last_code, 128);
        check(m_wave == 0, "R10 held press shape", m_wave, 0);

        // R9: fine change mid-period keeps the running spacing
        repeat (100) @(posedge clk);
        #1 fine_tune = 4'd9;
        wait_wrap();
        check(m_delay == 41, "R9 dwell taken at boundary", m_delay, 41);
        repeat (41 * 3) @(posedge clk);
        #1;

        // R1: reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(sample_code == 128, "R1 mid-run reset code", sample_code, 128);
        check(sample_strobe == 1'b0, "R1 mid-run reset strobe", sample_strobe, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (200) @(posedge clk);
        #1;
        finish_run();
    end

endmodule